// File: doc/BRIEF.md
# Overflow-Safe Event Buffer Controller

The controller sits between the event builder of a readout board and its output stage. It produces exactly one output record for every event it accepts, so the output stream stays in step with the trigger stream. Each accepted event takes a slot in an ordered slot queue. Its payload word goes into a data buffer when the buffer has room.

When the data buffer is full, the event still takes its slot, but the payload is discarded. The record later leaves as an empty record with a lost flag set, in exactly the position the event would have held. The controller keeps a saturating count of lost events, a saturating count of overflow episodes, a sticky overflow flag and a peak-occupancy register. If the slot queue itself is full, the event cannot be tracked at all. The controller then drops it and raises a sticky out-of-sync output.

A throttle output warns upstream logic when the buffer fill level reaches a programmable percentage of its capacity.

Top module: `evbuf_ctrl`

## Requirements
- R1: Records leave in acceptance order, one per accepted event. `out_evnum` starts at 0 after reset and increments by one on every record taken (`out_valid` and `out_ready` both high).
- R2: An event that arrives while the data buffer holds DEPTH words (counted at the start of that cycle) still gets a slot. It leaves as a record with `out_lost`=1 and `out_data`=0. Stored payloads come out unaltered and keep their order.
- R3: Register address 1 holds the number of lost events. It saturates at 2^CW-1, and any write to it clears it.
- R4: Register address 2 has the following layout:
  - bit CW is a sticky overflow flag, set by any lost event;
  - bits CW-1:0 count overflow episodes, where an episode is a lost event whose previously accepted event was stored. This count saturates at 2^CW-1.

  A write to address 2 clears the flag, the episode count and the out-of-sync flag.
- R5: An event that arrives while SLOTS records are pending is dropped. It produces no record and is not counted as lost. It sets `out_of_sync`, which stays high until a write to address 2. Status bit CW+1 mirrors `out_of_sync`.
- R6: Register address 0 holds the throttle percentage P (7 bits, writable and readable). The throttle state updates one cycle after the occupancy changes, as follows:
  - it sets when occupancy*100 >= P*DEPTH;
  - it clears when (occupancy+1)*100 < P*DEPTH;
  - otherwise it holds its value.
- R7: Register address 3 holds the largest occupancy seen, updated every cycle. A write to it clears it to 0.
- R8: After reset, the block is in this state:
  - `out_valid`, `throttle` and `out_of_sync` are 0;
  - P is 100;
  - the lost count, the status word and the peak occupancy are 0.
- R9: While `out_valid` is high and `out_ready` is low, the front record (`out_data`, `out_lost`, `out_evnum`) stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | One event arrives this cycle |
| ev_data | input | DW | Payload word of the arriving event |
| out_valid | output | 1 | A record is pending |
| out_ready | input | 1 | Downstream takes the pending record |
| out_data | output | DW | Payload of the record, 0 when lost |
| out_lost | output | 1 | Record is an empty substitute for a lost payload |
| out_evnum | output | EW | Sequence number of the record |
| throttle | output | 1 | Fill level at or above the programmed percentage |
| out_of_sync | output | 1 | Sticky: an event was dropped because the slot queue was full |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Register read data for `cfg_addr` |

## Verification
Saturating the episode counter is the hardest state to reach from the ports. Every episode needs a stored event followed by a lost one, and the buffer must be refilled between episodes. The bench therefore reduces CW to 4 and runs sixteen rounds. Each round fills the data buffer with stored events, forces one loss, and then drains every record. Reaching slot-queue overflow is similar: the bench holds `out_ready` low while the data buffer fills and lost records pile up until all slots are used. It then sends one more event.

// File: rtl/evbuf_ctrl.sv
module evbuf_ctrl #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int SLOTS = 16,
  parameter int CW    = 8,
  parameter int EW    = 16,
  parameter int PW    = 7,
  parameter int RW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [DW-1:0] ev_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_lost,
  output logic [EW-1:0] out_evnum,
  output logic          throttle,
  output logic          out_of_sync,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata
);
  localparam int AW  = $clog2(DEPTH);
  localparam int OW  = $clog2(DEPTH + 1);
  localparam int SAW = $clog2(SLOTS);
  localparam int SOW = $clog2(SLOTS + 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [OW-1:0]  occ, peak;
  logic [SLOTS-1:0] slot_lost;
  logic [SAW-1:0] swp, srp;
  logic [SOW-1:0] scnt;
  logic [CW-1:0]  lost_cnt, err_cnt;
  logic [PW-1:0]  pct;
  logic           ovf, last_lost;
  logic [31:0]    need, occ100, occ1_100;

  wire slot_full = (scnt == SOW'(SLOTS));
  wire data_full = (occ == OW'(DEPTH));
  wire acc       = ev_valid && !slot_full;
  wire store     = acc && !data_full;
  wire lose      = acc && data_full;
  wire drop      = ev_valid && slot_full;
  wire pop       = out_valid && out_ready;
  wire pop_data  = pop && !out_lost;

  wire wr_pct  = cfg_wr && (cfg_addr == 2'd0);
  wire wr_lost = cfg_wr && (cfg_addr == 2'd1);
  wire wr_stat = cfg_wr && (cfg_addr == 2'd2);
  wire wr_peak = cfg_wr && (cfg_addr == 2'd3);

  assign out_valid = (scnt != '0);
  assign out_lost  = slot_lost[srp];
  assign out_data  = out_lost ? '0 : mem[rp];

  function automatic logic [AW-1:0] dnext(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [SAW-1:0] snext(input logic [SAW-1:0] p);
    return (p == SAW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (store) mem[wp] <= ev_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      occ <= '0;
    end else begin
      if (store) wp <= dnext(wp);
      if (pop_data) rp <= dnext(rp);
      occ <= occ + OW'(store) - OW'(pop_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_lost <= '0;
      swp <= '0;
      srp <= '0;
      scnt <= '0;
      out_evnum <= '0;
    end else begin
      if (acc) begin
        slot_lost[swp] <= lose;
        swp <= snext(swp);
      end
      if (pop) begin
        srp <= snext(srp);
        out_evnum <= out_evnum + 1'b1;
      end
      scnt <= scnt + SOW'(acc) - SOW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_cnt <= '0;
      err_cnt <= '0;
      ovf <= 1'b0;
      out_of_sync <= 1'b0;
      last_lost <= 1'b0;
    end else begin
      if (wr_lost) lost_cnt <= '0;
      else if (lose && lost_cnt != '1) lost_cnt <= lost_cnt + 1'b1;
      if (wr_stat) err_cnt <= '0;
      else if (lose && !last_lost && err_cnt != '1) err_cnt <= err_cnt + 1'b1;
      if (acc) last_lost <= lose;
      ovf <= lose | (ovf & !wr_stat);
      out_of_sync <= drop | (out_of_sync & !wr_stat);
    end
  end

  always_comb begin
    need     = 32'(pct) * 32'(DEPTH);
    occ100   = 32'(occ) * 32'd100;
    occ1_100 = (32'(occ) + 32'd1) * 32'd100;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pct <= PW'(100);
      peak <= '0;
      throttle <= 1'b0;
    end else begin
      if (wr_pct) pct <= cfg_wdata[PW-1:0];
      if (wr_peak) peak <= '0;
      else if (occ > peak) peak <= occ;
      if (occ100 >= need) throttle <= 1'b1;
      else if (occ1_100 < need) throttle <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = RW'(pct);
      2'd1:    cfg_rdata = RW'(lost_cnt);
      2'd2:    cfg_rdata = RW'({out_of_sync, ovf, err_cnt});
      default: cfg_rdata = RW'(peak);
    endcase
  end

  assert_evnum_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> out_evnum == $past(out_evnum) + 1'b1);

  assert_lost_keeps_occ_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lose && !pop_data |=> occ == $past(occ));

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));

  assert_lost_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lost |=> lost_cnt >= $past(lost_cnt));

  assert_oos_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_sync && !wr_stat |=> out_of_sync);

  assert_throttle_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(throttle) |-> $past(occ100) >= $past(need));

  assert_peak_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_peak |=> peak >= $past(occ));

  assert_hold_front_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_lost));
endmodule

// File: tb/evbuf_ctrl_test.sv
module evbuf_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, DEPTH = 8, SLOTS = 16, CW = 4, EW = 16, RW = 16;
  // row bits: {push, pop, expected throttle after the row's edge}, P = 50
  localparam logic [2:0] VEC [0:12] = '{
    3'b100, 3'b100, 3'b100, 3'b100, 3'b101,
    3'b011, 3'b011, 3'b011, 3'b010,
    3'b100, 3'b100, 3'b100, 3'b001};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, out_ready = 1'b0, cfg_wr = 1'b0;
  logic [DW-1:0] ev_data = '0;
  logic [1:0] cfg_addr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic out_valid, out_lost, throttle, out_of_sync;
  logic [DW-1:0] out_data;
  logic [EW-1:0] out_evnum;
  logic [RW-1:0] cfg_rdata;
  int checks = 0, errors = 0, nevt = 0;
  logic done = 1'b0;

  evbuf_ctrl #(.DW(DW), .DEPTH(DEPTH), .SLOTS(SLOTS), .CW(CW), .EW(EW), .PW(7), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_data(ev_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_lost(out_lost), .out_evnum(out_evnum), .throttle(throttle),
    .out_of_sync(out_of_sync), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic push, input logic [DW-1:0] d, input logic rdy);
    @(negedge clk);
    ev_valid = push; ev_data = d; out_ready = rdy;
    if (rdy && out_valid) nevt++;
    @(posedge clk); #1;
    ev_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = RW'(d);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    cfg_addr = a; #1;
    v = int'(cfg_rdata);
  endtask

  task automatic take(input string req, input int lost, input int d);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " lost"}, int'(out_lost), lost);
    chk({req, " data"}, int'(out_data), d);
    chk("R1 evnum", int'(out_evnum), nevt);
    cyc(1'b0, '0, 1'b1);
  endtask

  task automatic drain(output int n);
    n = 0;
    while (out_valid) begin
      cyc(1'b0, '0, 1'b1);
      n++;
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int v, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R8 reset state
    chk("R8 out_valid", int'(out_valid), 0);
    chk("R8 throttle", int'(throttle), 0);
    chk("R8 out_of_sync", int'(out_of_sync), 0);
    rd(2'd0, v); chk("R8 pct", v, 100);
    rd(2'd1, v); chk("R8 lost", v, 0);
    rd(2'd2, v); chk("R8 status", v, 0);
    rd(2'd3, v); chk("R8 peak", v, 0);

    // R6 throttle hysteresis table, P = 50
    wr(2'd0, 50);
    rd(2'd0, v); chk("R6 pct readback", v, 50);
    for (int i = 0; i < 13; i++) begin
      cyc(VEC[i][2], DW'(i), VEC[i][1]);
      chk($sformatf("R6 throttle row %0d", i), int'(throttle), int'(VEC[i][0]));
    end
    wr(2'd0, 100);
    while (out_valid) take("R1 table drain", 0, int'(out_data));

    // R1 order, R9 hold
    cyc(1'b1, 16'h00A1, 1'b0);
    cyc(1'b1, 16'h00B2, 1'b0);
    cyc(1'b1, 16'h00C3, 1'b0);
    v = int'(out_evnum);
    cyc(1'b0, '0, 1'b0);
    chk("R9 hold data", int'(out_data), 16'h00A1);
    chk("R9 hold evnum", int'(out_evnum), v);
    take("R1 first", 0, 16'h00A1);
    take("R1 second", 0, 16'h00B2);
    take("R1 third", 0, 16'h00C3);

    // R2 overflow with substitute records
    wr(2'd3, 0);
    for (int i = 0; i < 8; i++) cyc(1'b1, DW'(16'h0100 + i), 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 16'h07FF, 1'b0);
    rd(2'd1, v); chk("R3 lost count", v, 3);
    rd(2'd2, v); chk("R4 status ovf+episode", v, 16'h11);
    rd(2'd3, v); chk("R7 peak full", v, 8);
    chk("R6 throttle at full", int'(throttle), 1);
    for (int i = 0; i < 8; i++) take("R2 stored", 0, 16'h0100 + i);
    for (int i = 0; i < 3; i++) take("R2 lost", 1, 0);
    chk("R2 empty after", int'(out_valid), 0);

    // R3/R4 clear and saturation
    wr(2'd1, 0); wr(2'd2, 0);
    rd(2'd1, v); chk("R3 cleared", v, 0);
    rd(2'd2, v); chk("R4 cleared", v, 0);
    for (int r = 0; r < 16; r++) begin
      for (int i = 0; i < 8; i++) cyc(1'b1, DW'(r), 1'b0);
      cyc(1'b1, '0, 1'b0);
      drain(n);
    end
    rd(2'd1, v); chk("R3 saturated", v, 15);
    rd(2'd2, v); chk("R4 episodes saturated", v, 16'h1F);

    // R5 slot queue overflow
    wr(2'd1, 0); wr(2'd2, 0);
    for (int i = 0; i < 16; i++) cyc(1'b1, DW'(i), 1'b0);
    chk("R5 no oos when exactly full", int'(out_of_sync), 0);
    cyc(1'b1, 16'h0BAD, 1'b0);
    chk("R5 oos set", int'(out_of_sync), 1);
    rd(2'd1, v); chk("R5 drop not counted lost", v, 8);
    rd(2'd2, v); chk("R5 status oos bit", v, 16'h31);
    drain(n);
    chk("R5 record count", n, 16);
    chk("R5 oos sticky", int'(out_of_sync), 1);
    wr(2'd2, 0);
    chk("R5 oos cleared", int'(out_of_sync), 0);

    // R7 peak clear and re-capture
    wr(2'd3, 0);
    rd(2'd3, v); chk("R7 peak cleared", v, 0);
    cyc(1'b1, 16'h0001, 1'b0);
    cyc(1'b1, 16'h0002, 1'b0);
    cyc(1'b0, '0, 1'b0);
    rd(2'd3, v); chk("R7 peak two", v, 2);
    take("R1 tail", 0, 1);
    take("R1 tail", 0, 2);

    done = 1'b1;
    finish_run();
  end
endmodule